// File: doc/BRIEF.md
# Banked ECC Memory Port with Run-Time Shutdown

This block is a single-clock memory port with separate write and read addresses. Its storage is split into a parameter-chosen number of equal banks. Each stored word carries a single-error-correct, double-error-detect (SECDED) code. Every read returns the decoded data together with a two-bit ECC status. The upper address bits choose a bank. An address that names a bank beyond the enabled count is out of range. A write there is dropped, and a read there returns a value that callers must ignore.

A shutdown input stands in for powering the port down. While it is high, every bank ignores writes and the read outputs sit at zero. Raising it also wipes out everything stored. Once shutdown is released, each location that has not been written since reads as zero with clear flags. A corrected error is fixed only on the output path, so the stored word keeps its fault and reports it again on every read. A test-only mask input flips chosen codeword bits as a word is written. This lets a bench create single-bit and double-bit faults on purpose.

Top module: `banked_ecc_ram`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. A read with `rd_en` high at clock edge t shows that word on `rd_data` right after edge t, one clock later, with `ecc_flags` updated in the same cycle.
- R2: While `rd_en` is low and shutdown is low, `rd_data` and `ecc_flags` keep their last values.
- R3: Address bits [ADDR_W-1:BANK_AW] select the bank, and only banks 0 to EN_BANKS-1 exist. A write to any other bank leaves every stored word unchanged.
- R4: A stored word with exactly one flipped codeword bit reads back with the original data and `ecc_flags` = 2'b11.
- R5: A stored word with exactly two flipped codeword bits reads back with `ecc_flags` = 2'b01, where bit 0 means an error was detected and bit 1 means it was corrected.
- R6: Correction is never written back. A word with a single-bit fault reports `ecc_flags` = 2'b11 on every repeated read.
- R7: While `shutdown` is high, `rd_data` and `ecc_flags` are zero and writes are ignored.
- R8: After `shutdown` falls, the outputs are zero. Every location written before or during shutdown then reads as zero data with `ecc_flags` = 2'b00 until it is written again.
- R9: After reset, `rd_data` and `ecc_flags` are zero.
- R10: Bit i of `err_inj_mask` inverts codeword bit i of the word being written. In the codeword, bit 0 is the overall parity, bits at power-of-two positions are the Hamming check bits, and the other positions hold the data bits in ascending order.
- R11: A word written with a zero mask reads back with `ecc_flags` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Active-high power-down of all banks; discards contents |
| wr_en | input | 1 | Write enable for `wr_addr` |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| err_inj_mask | input | CW_W | Test-only codeword bit flips applied at write time |
| rd_en | input | 1 | Read enable for `rd_addr` |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Decoded read data |
| ecc_flags | output | 2 | Bit 0 = error detected, bit 1 = error corrected |

## Verification
The bench writes to the disabled banks using addresses whose low bits match stored words. A decoder that dropped the bank bits would then overwrite those words, and the check on the word's value would catch it. The bench injects single-bit faults into a data bit, the overall parity bit and the top check bit, and reads each faulty word twice. A decoder that mislocated the syndrome would return wrong data. A design that wrote the correction back would report clean flags on the second read. Double-bit faults must give detect-only flags, so a design that miscorrects them is exposed. Around shutdown, the bench writes during power-down, reads during it and reads after release. A design that kept old contents or accepted the write returns non-zero data.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
   // Number of Hamming check bits for a given data width
   function automatic int ham_bits(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // Full SECDED codeword width: data + Hamming bits + overall parity
   function automatic int cw_bits(input int dw);
      return dw + ham_bits(dw) + 1;
   endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
   parameter int DATA_W = 32,
   localparam int P     = ecc_ram_pkg::ham_bits(DATA_W),
   localparam int N     = DATA_W + P,
   localparam int CW_W  = N + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   cw
);
   logic [N:0] ham;

   always_comb begin
      int k;
      ham = '0;
      k   = 0;
      for (int pos = 1; pos <= N; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            ham[pos] = data[k];
            k++;
         end
      end
      for (int j = 0; j < P; j++) begin
         logic par;
         par = 1'b0;
         for (int pos = 1; pos <= N; pos++)
            if (((pos >> j) & 1) == 1) par = par ^ ham[pos];
         ham[1 << j] = par;
      end
      cw    = ham;
      cw[0] = ^ham[N:1];
   end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
   parameter int DATA_W = 32,
   localparam int P     = ecc_ram_pkg::ham_bits(DATA_W),
   localparam int N     = DATA_W + P,
   localparam int CW_W  = N + 1
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data,
   output logic              err_det,
   output logic              err_cor
);
   logic [P-1:0]    syn;
   logic            ovp;
   logic            fixable;
   logic [CW_W-1:0] fix;

   always_comb begin
      int k;
      syn = '0;
      for (int pos = 1; pos <= N; pos++)
         if (cw[pos]) syn = syn ^ P'(pos);
      ovp     = ^cw;
      // odd overall parity means one flipped bit; position 0 is the parity bit itself
      fixable = ovp && (int'(syn) <= N);
      fix     = cw;
      for (int pos = 0; pos <= N; pos++)
         if (fixable && (int'(syn) == pos)) fix[pos] = ~cw[pos];
      data = '0;
      k    = 0;
      for (int pos = 1; pos <= N; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            data[k] = fix[pos];
            k++;
         end
      end
      err_det = ovp || (syn != '0);
      err_cor = fixable;
   end
endmodule

// File: rtl/ecc_ram_bank.sv
module ecc_ram_bank #(
   parameter int CW_W    = 39,
   parameter int BANK_AW = 6,
   localparam int DEPTH  = 1 << BANK_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               we,
   input  logic [BANK_AW-1:0] waddr,
   input  logic [CW_W-1:0]    wcw,
   input  logic               re,
   input  logic [BANK_AW-1:0] raddr,
   output logic [CW_W-1:0]    rcw,
   output logic               rvld
);
   logic [CW_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] live;

   always_ff @(posedge clk)
      if (we && !clear) mem[waddr] <= wcw;

   // per-word written marker; clearing it models loss of contents
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           live <= '0;
      else if (clear)       live <= '0;
      else if (we)          live[waddr] <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcw  <= '0;
         rvld <= 1'b0;
      end else if (clear) begin
         rcw  <= '0;
         rvld <= 1'b0;
      end else if (re) begin
         rcw  <= mem[raddr];
         rvld <= live[raddr];
      end
   end
endmodule

// File: rtl/banked_ecc_ram.sv
module banked_ecc_ram #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 10,
   parameter int BANK_AW   = 6,
   parameter int EN_BANKS  = 3,
   localparam int CW_W     = ecc_ram_pkg::cw_bits(DATA_W),
   localparam int BSEL_W   = ADDR_W - BANK_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shutdown,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CW_W-1:0]   err_inj_mask,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        ecc_flags
);
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
      $error("DATA_W must be 1..64");
   end
   if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must be 10..16");
   end
   if (BANK_AW < 1 || BANK_AW >= ADDR_W || BANK_AW > 10) begin : g_bad_bank
      $error("BANK_AW must be 1..10 and below ADDR_W");
   end
   if (EN_BANKS < 1 || EN_BANKS > (1 << BSEL_W)) begin : g_bad_en
      $error("EN_BANKS out of range for address split");
   end

   logic [BSEL_W-1:0]  wr_bank, rd_bank, rsel_q;
   logic               rin_q;
   logic [EN_BANKS-1:0] bank_we, bank_re, bank_rvld;
   logic [CW_W-1:0]    bank_rcw [EN_BANKS];
   logic [CW_W-1:0]    enc_cw, store_cw, sel_cw;
   logic               sel_vld;
   logic [DATA_W-1:0]  dec_data;
   logic               dec_det, dec_cor;

   assign wr_bank  = wr_addr[ADDR_W-1:BANK_AW];
   assign rd_bank  = rd_addr[ADDR_W-1:BANK_AW];
   assign store_cw = enc_cw ^ err_inj_mask;

   ecc_secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data (wr_data),
      .cw   (enc_cw)
   );

   always_comb begin
      for (int b = 0; b < EN_BANKS; b++) begin
         bank_we[b] = wr_en && !shutdown && (int'(wr_bank) == b);
         bank_re[b] = rd_en && !shutdown && (int'(rd_bank) == b);
      end
   end

   for (genvar b = 0; b < EN_BANKS; b++) begin : g_bank
      ecc_ram_bank #(.CW_W(CW_W), .BANK_AW(BANK_AW)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (shutdown),
         .we    (bank_we[b]),
         .waddr (wr_addr[BANK_AW-1:0]),
         .wcw   (store_cw),
         .re    (bank_re[b]),
         .raddr (rd_addr[BANK_AW-1:0]),
         .rcw   (bank_rcw[b]),
         .rvld  (bank_rvld[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_q <= '0;
         rin_q  <= 1'b0;
      end else if (shutdown) begin
         rin_q  <= 1'b0;
      end else if (rd_en) begin
         rsel_q <= rd_bank;
         rin_q  <= int'(rd_bank) < EN_BANKS;
      end
   end

   always_comb begin
      sel_cw  = '0;
      sel_vld = 1'b0;
      for (int b = 0; b < EN_BANKS; b++) begin
         if (int'(rsel_q) == b) begin
            sel_cw  = bank_rcw[b];
            sel_vld = bank_rvld[b];
         end
      end
      sel_vld = sel_vld && rin_q;
   end

   ecc_secded_dec #(.DATA_W(DATA_W)) u_dec (
      .cw      (sel_cw),
      .data    (dec_data),
      .err_det (dec_det),
      .err_cor (dec_cor)
   );

   always_comb begin
      if (shutdown || !sel_vld) begin
         rd_data   = '0;
         ecc_flags = 2'b00;
      end else begin
         rd_data   = dec_data;
         ecc_flags = {dec_cor, dec_det};
      end
   end
endmodule

// File: rtl/banked_ecc_ram_chk.sv
module banked_ecc_ram_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutdown,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        ecc_flags
);
   // R5: correction is never claimed without detection
   p_cor_implies_det_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_flags[1] |-> ecc_flags[0]);

   // R7: outputs are quiet during shutdown
   p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (rd_data == '0 && ecc_flags == 2'b00));

   // R2: idle read port holds its outputs
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !shutdown) |=> (shutdown || ($stable(rd_data) && $stable(ecc_flags))));

   // R8: outputs are zero in the cycle shutdown is released
   p_release_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown) |-> (rd_data == '0 && ecc_flags == 2'b00));
endmodule

bind banked_ecc_ram banked_ecc_ram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shutdown  (shutdown),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .ecc_flags (ecc_flags)
);

// File: tb/test_banked_ecc_ram.sv
module test_banked_ecc_ram;
   localparam int DW = 32;
   localparam int AW = 10;
   localparam int CW = ecc_ram_pkg::cw_bits(DW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          shutdown = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] err_inj_mask = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    ecc_flags;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [DW-1:0] d;
      logic [1:0]    f;
      bit            chk_d;
      string         tag;
   } exp_t;
   exp_t exp_q[$];
   exp_t mon_e;
   logic rd_seen = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   banked_ecc_ram i_banked_ecc_ram (
      .clk, .rst_n, .shutdown, .wr_en, .wr_addr, .wr_data, .err_inj_mask,
      .rd_en, .rd_addr, .rd_data, .ecc_flags
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare each read result one clock after its read edge
   always @(posedge clk) rd_seen <= rd_en && !shutdown;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         mon_e = exp_q.pop_front();
         if (mon_e.chk_d) chk({mon_e.tag, " data"}, 64'(rd_data), 64'(mon_e.d));
         chk({mon_e.tag, " flags"}, 64'(ecc_flags), 64'(mon_e.f));
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] m);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; err_inj_mask = m;
      @(negedge clk);
      wr_en = 1'b0; err_inj_mask = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] f,
                     input bit chk_d, input string tag);
      exp_t e;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      e.d = d; e.f = f; e.chk_d = chk_d; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset data", 64'(rd_data), 64'd0);
      chk("R9 reset flags", 64'(ecc_flags), 64'd0);
      rst_n = 1'b1;

      // R1 / R11: plain writes across bank edges
      wr(10'd0,   32'hA5A5_0001, '0);
      wr(10'd63,  32'h1234_5678, '0);
      wr(10'd64,  32'hDEAD_BEEF, '0);
      wr(10'd191, 32'h0F0F_F0F0, '0);
      rd(10'd0,   32'hA5A5_0001, 2'b00, 1, "R1 R11 addr0");
      rd(10'd64,  32'hDEAD_BEEF, 2'b00, 1, "R1 R11 addr64");
      rd(10'd191, 32'h0F0F_F0F0, 2'b00, 1, "R1 R11 addr191");
      rd(10'd63,  32'h1234_5678, 2'b00, 1, "R1 R11 addr63");

      // R2: idle port holds the last result
      repeat (3) @(negedge clk);
      chk("R2 hold data", 64'(rd_data), 64'h1234_5678);
      chk("R2 hold flags", 64'(ecc_flags), 64'd0);

      // R3: writes to disabled banks alias nothing
      wr(10'd192,  32'hFFFF_0000, '0);
      wr(10'd1023, 32'h5555_AAAA, '0);
      wr(10'd448,  32'h7777_7777, '0);
      rd(10'd0,  32'hA5A5_0001, 2'b00, 1, "R3 addr0 intact");
      rd(10'd63, 32'h1234_5678, 2'b00, 1, "R3 addr63 intact");
      rd(10'd128 + 10'd0, 32'h0, 2'b00, 0, "R3 bank2 unwritten flags");

      // R4 / R10 / R6: single flips at data, parity and top check positions
      wr(10'd10, 32'hCAFE_0010, CW'(1) << 5);
      rd(10'd10, 32'hCAFE_0010, 2'b11, 1, "R4 R10 data-bit flip");
      rd(10'd10, 32'hCAFE_0010, 2'b11, 1, "R6 repeat read still faulty");
      wr(10'd11, 32'h0000_0011, CW'(1));
      rd(10'd11, 32'h0000_0011, 2'b11, 1, "R4 R10 parity-bit flip");
      wr(10'd75, 32'h8000_0001, CW'(1) << 32);
      rd(10'd75, 32'h8000_0001, 2'b11, 1, "R4 R10 check-bit flip");
      wr(10'd12, 32'hFFFF_FFFF, CW'(1) << (CW - 1));
      rd(10'd12, 32'hFFFF_FFFF, 2'b11, 1, "R4 R10 top-bit flip");

      // R5: double flips are detected, not corrected
      wr(10'd13, 32'h1357_9BDF, (CW'(1) << 3) | (CW'(1) << 9));
      rd(10'd13, 32'h0, 2'b01, 0, "R5 double flip");
      wr(10'd150, 32'h2468_ACE0, CW'(3));
      rd(10'd150, 32'h0, 2'b01, 0, "R5 double flip incl parity");
      rd(10'd150, 32'h0, 2'b01, 0, "R6 double flip persists");

      // R7: shutdown quiets outputs and drops writes
      @(negedge clk);
      shutdown = 1'b1;
      @(negedge clk);
      chk("R7 off data", 64'(rd_data), 64'd0);
      chk("R7 off flags", 64'(ecc_flags), 64'd0);
      wr_en = 1'b1; wr_addr = 10'd20; wr_data = 32'h9999_0020;
      rd_en = 1'b1; rd_addr = 10'd0;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R7 read during off", 64'(rd_data), 64'd0);
      @(negedge clk);
      shutdown = 1'b0;
      #1;
      chk("R8 released data", 64'(rd_data), 64'd0);
      chk("R8 released flags", 64'(ecc_flags), 64'd0);

      // R7 / R8: contents gone and the dropped write left nothing
      rd(10'd20, 32'h0, 2'b00, 1, "R7 write during off ignored");
      rd(10'd0,  32'h0, 2'b00, 1, "R8 addr0 erased");
      rd(10'd10, 32'h0, 2'b00, 1, "R8 faulty word erased");
      wr(10'd0,  32'hB0B0_0000, '0);
      rd(10'd0,  32'hB0B0_0000, 2'b00, 1, "R8 rewrite after release");

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule